// File: doc/BRIEF.md
# Clock Source Selection Controller

This block decides whether a microcontroller core runs from its external crystal or from an on-chip RC oscillator. Software sees a small control register with three bits. The first is a crystal-select bit that software writes to request the crystal. The second is a read-only status bit that reports which source the clock multiplexer is really using. The third picks how the core resumes from power-down. The block drives a clock-select line toward an external multiplexer and a CPU hold line that stalls the core while it is powered down or waiting for the crystal to stabilise.

The crystal oscillator is modelled by a warm-up counter. It is stable after power-on. A power-down request stops it. A wake event restarts it, and it reports ready after a programmable number of cycles. Software can force the crystal off with a disable input. A request for the crystal is refused silently unless the crystal is ready and not disabled. The register bits survive every reset except power-on. The general reset only returns the core's run state to awake.

None of the pins carries a data stream, so there is no valid/ready handshake. The write port is a plain one-cycle strobe with data, and the readback is combinational from the register state. The general reset input is sampled on the clock. Power-on reset is asynchronous.

Top module: `clk_src_ctrl`

## Requirements
- R1: After power-on reset, readback is 3'b001, with crystal-select (bit 0) = 1, status (bit 1) = 0 and resume-on-RC (bit 2) = 0. In the same state sel_xtal = 1, cpu_hold = 0 and xtal_ready = 1.
- R2: A write with bit 0 = 1 sets crystal-select only if xtal_ready = 1 and xtal_off = 0 in the write cycle. Otherwise it leaves the bit unchanged. A write with bit 0 = 0 always clears it.
- R3: Holding rst_n low leaves bit 0 and bit 2 unchanged. At the next edge it clears cpu_hold and restarts a stopped crystal.
- R4: Bit 1 of a write is discarded. Status is never changed by a write.
- R5: While cpu_hold = 0, at each edge sel_xtal becomes (crystal-select AND xtal_ready), and status becomes its inverse (1 = RC). While cpu_hold = 1 the source does not change.
- R6: A pd_req while not powered down makes cpu_hold = 1 and xtal_ready = 0 after the next edge.
- R7: With bit 2 = 1, a wake event drops cpu_hold after that edge. The core runs on RC (sel_xtal = 0) from the following edge until the crystal is ready.
- R8: With bit 2 = 0, cpu_hold stays 1 after a wake until xtal_ready is 1. It is released one edge later.
- R9: The crystal reports ready WARM_CYCLES edges after the wake edge, counting the wake edge itself, or after xtal_off is released.
- R10: xtal_off = 1 makes xtal_ready = 0 after the next edge and resets the warm-up count.
- R11: pd_req while already powered down, and wake while not powered down, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | General reset, active low, sampled on clock |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Write data: bit 0 crystal-select, bit 1 ignored, bit 2 resume-on-RC |
| xtal_off | input | 1 | Crystal disable |
| pd_req | input | 1 | Power-down request |
| wake | input | 1 | Wake event |
| rd_data | output | 3 | Register readback: bit 0 crystal-select, bit 1 status, bit 2 resume-on-RC |
| sel_xtal | output | 1 | Clock mux select, 1 = crystal |
| cpu_hold | output | 1 | Core stall |
| xtal_ready | output | 1 | Modelled crystal-stable flag |

## Verification
The hardest situation to reach is the hold window after a wake with resume-on-RC cleared. It needs a full power-down, a wake, and the crystal counter running out. A rejected crystal request also has to follow a disable being released partway through the warm-up. The stimulus first turns the crystal off to clear its ready flag. It then tries a crystal write before the count expires, and only after that powers down and wakes with each setting of the resume bit. A behavioural model computes every output on every cycle, so the exact edge of each release is compared.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned CTRL_W     = 3;
  localparam int unsigned XSEL_BIT   = 0;
  localparam int unsigned STAT_BIT   = 1;
  localparam int unsigned RESUME_BIT = 2;
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic              wr_xsel,
  input  logic              wr_resume,
  input  logic              xtal_ready,
  input  logic              xtal_off,
  output logic              xtal_sel,
  output logic              resume_rc
);
  logic xsel_grant;

  // crystal request honoured only for a stable, enabled crystal
  assign xsel_grant = xtal_ready & ~xtal_off;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      xtal_sel  <= 1'b1;
      resume_rc <= 1'b0;
    end else if (wr_en) begin
      if (!wr_xsel)        xtal_sel <= 1'b0;
      else if (xsel_grant) xtal_sel <= 1'b1;
      resume_rc <= wr_resume;
    end
  end
endmodule

// File: rtl/csel_warmup.sv
module csel_warmup #(
  parameter int unsigned WARM_CYCLES = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic enter_pd,
  input  logic wake_start,
  input  logic xtal_off,
  output logic xtal_ready
);
  localparam int unsigned CNT_W = (WARM_CYCLES > 1) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARM_CYCLES - 1);

  logic             osc_run;
  logic [CNT_W-1:0] cnt;
  logic             counting;

  assign counting = (osc_run | wake_start) & ~xtal_ready;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      osc_run    <= 1'b1;
      xtal_ready <= 1'b1;
      cnt        <= '0;
    end else if (enter_pd) begin
      osc_run    <= 1'b0;
      xtal_ready <= 1'b0;
      cnt        <= '0;
    end else begin
      if (wake_start) osc_run <= 1'b1;
      if (xtal_off) begin
        xtal_ready <= 1'b0;
        cnt        <= '0;
      end else if (counting) begin
        if (cnt == LAST) begin
          xtal_ready <= 1'b1;
          cnt        <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/csel_power.sv
module csel_power (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic pd_req,
  input  logic wake,
  input  logic resume_rc,
  input  logic xtal_sel,
  input  logic xtal_ready,
  output logic enter_pd,
  output logic wake_start,
  output logic cpu_hold,
  output logic src_rc
);
  logic asleep;
  logic warm_wait;

  assign cpu_hold   = asleep | warm_wait;
  assign enter_pd   = pd_req & ~asleep & rst_n;
  assign wake_start = asleep & (wake | ~rst_n);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      asleep    <= 1'b0;
      warm_wait <= 1'b0;
      src_rc    <= 1'b0;
    end else begin
      // source moves only while the core is running
      if (!cpu_hold) src_rc <= ~(xtal_sel & xtal_ready);
      if (!rst_n) begin
        asleep    <= 1'b0;
        warm_wait <= 1'b0;
      end else if (asleep) begin
        if (wake) begin
          asleep    <= 1'b0;
          warm_wait <= ~resume_rc;
        end
      end else if (pd_req) begin
        asleep    <= 1'b1;
        warm_wait <= 1'b0;
      end else if (warm_wait && xtal_ready) begin
        warm_wait <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import csel_pkg::*;
#(
  parameter int unsigned WARM_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              xtal_off,
  input  logic              pd_req,
  input  logic              wake,
  output logic [CTRL_W-1:0] rd_data,
  output logic              sel_xtal,
  output logic              cpu_hold,
  output logic              xtal_ready
);
  logic xtal_sel, resume_rc, src_rc, enter_pd, wake_start;

  csel_regs u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .wr_en      (wr_en),
    .wr_xsel    (wr_data[XSEL_BIT]),
    .wr_resume  (wr_data[RESUME_BIT]),
    .xtal_ready (xtal_ready),
    .xtal_off   (xtal_off),
    .xtal_sel   (xtal_sel),
    .resume_rc  (resume_rc)
  );

  csel_warmup #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk        (clk),
    .por_n      (por_n),
    .enter_pd   (enter_pd),
    .wake_start (wake_start),
    .xtal_off   (xtal_off),
    .xtal_ready (xtal_ready)
  );

  csel_power u_pwr (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .pd_req     (pd_req),
    .wake       (wake),
    .resume_rc  (resume_rc),
    .xtal_sel   (xtal_sel),
    .xtal_ready (xtal_ready),
    .enter_pd   (enter_pd),
    .wake_start (wake_start),
    .cpu_hold   (cpu_hold),
    .src_rc     (src_rc)
  );

  always_comb begin
    rd_data             = '0;
    rd_data[XSEL_BIT]   = xtal_sel;
    rd_data[STAT_BIT]   = src_rc;
    rd_data[RESUME_BIT] = resume_rc;
  end

  assign sel_xtal = ~src_rc;
endmodule

// File: rtl/csel_chk.sv
module csel_chk
  import csel_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic              xtal_off,
  input logic              pd_req,
  input logic [CTRL_W-1:0] rd_data,
  input logic              sel_xtal,
  input logic              cpu_hold,
  input logic              xtal_ready
);
  AST_XSEL_GUARDED: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rd_data[XSEL_BIT]) |-> $past(wr_en && wr_data[XSEL_BIT] && xtal_ready && !xtal_off)); // R2

  AST_GENRST_KEEPS_BITS: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !wr_en) |=> ($stable(rd_data[XSEL_BIT]) && $stable(rd_data[RESUME_BIT]))); // R3

  AST_STATUS_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_data[STAT_BIT] && cpu_hold) |=> $stable(rd_data[STAT_BIT])); // R4

  AST_SRC_FROZEN_IN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    cpu_hold |=> $stable(sel_xtal)); // R5

  AST_PD_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    (!cpu_hold && pd_req && rst_n) |=> (cpu_hold && !xtal_ready)); // R6

  AST_WARM_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_hold && xtal_ready && !pd_req) |=> !cpu_hold); // R8

  AST_OFF_DROPS_READY: assert property (@(posedge clk) disable iff (!por_n)
    xtal_off |=> !xtal_ready); // R10
endmodule

bind clk_src_ctrl csel_chk i_csel_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .xtal_off   (xtal_off),
  .pd_req     (pd_req),
  .rd_data    (rd_data),
  .sel_xtal   (sel_xtal),
  .cpu_hold   (cpu_hold),
  .xtal_ready (xtal_ready)
);

// File: tb/test_clk_src_ctrl.sv
module test_clk_src_ctrl;
  localparam int WARM = 6;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, xtal_off = 1'b0, pd_req = 1'b0, wake = 1'b0;
  logic [2:0] wr_data = 3'b000;
  logic [2:0] rd_data;
  logic       sel_xtal, cpu_hold, xtal_ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  clk_src_ctrl #(.WARM_CYCLES(WARM)) i_clk_src_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .xtal_off(xtal_off), .pd_req(pd_req), .wake(wake), .rd_data(rd_data),
    .sel_xtal(sel_xtal), .cpu_hold(cpu_hold), .xtal_ready(xtal_ready)
  );

  always #10ns clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_xsel, m_rc, m_res, m_sleep, m_wait, m_run, m_rdy, m_cnt;
  always @(posedge clk) begin
    int hold, enter, wk, o_xsel, o_rdy, o_res, o_sleep;
    if (!por_n) begin
      m_xsel = 1; m_rc = 0; m_res = 0; m_sleep = 0; m_wait = 0;
      m_run = 1; m_rdy = 1; m_cnt = 0;
    end else begin
      o_xsel = m_xsel; o_rdy = m_rdy; o_res = m_res; o_sleep = m_sleep;
      hold  = (m_sleep || m_wait) ? 1 : 0;
      enter = (pd_req && !o_sleep && rst_n) ? 1 : 0;
      wk    = (o_sleep && (wake || !rst_n)) ? 1 : 0;
      if (wr_en) begin
        if (!wr_data[0]) m_xsel = 0;
        else if (o_rdy && !xtal_off) m_xsel = 1;
        m_res = wr_data[2];
      end
      if (!hold) m_rc = (o_xsel && o_rdy) ? 0 : 1;
      if (!rst_n) begin m_sleep = 0; m_wait = 0; end
      else if (o_sleep) begin
        if (wake) begin m_sleep = 0; m_wait = o_res ? 0 : 1; end
      end else if (pd_req) begin m_sleep = 1; m_wait = 0; end
      else if (m_wait && o_rdy) m_wait = 0;
      if (enter) begin m_run = 0; m_rdy = 0; m_cnt = 0; end
      else begin
        if (wk) m_run = 1;
        if (xtal_off) begin m_rdy = 0; m_cnt = 0; end
        else if (m_run && !o_rdy) begin
          if (m_cnt == WARM - 1) begin m_rdy = 1; m_cnt = 0; end
          else m_cnt++;
        end
      end
    end
    #5ns;
    if (!done) begin
      chk("R2 crystal-select bit", rd_data[0], m_xsel);
      chk("R5 status bit", rd_data[1], m_rc);
      chk("R7 resume bit", rd_data[2], m_res);
      chk("R5 sel_xtal", sel_xtal, 1 - m_rc);
      chk("R8 cpu_hold", cpu_hold, (m_sleep || m_wait) ? 1 : 0);
      chk("R9 xtal_ready", xtal_ready, m_rdy);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [2:0] d);
    wr_en = 1'b1; wr_data = d; tick(1); wr_en = 1'b0;
  endtask
  task automatic pulse_pd;
    pd_req = 1'b1; tick(1); pd_req = 1'b0;
  endtask
  task automatic pulse_wake;
    wake = 1'b1; tick(1); wake = 1'b0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    tick(3000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick(3);
    por_n = 1'b1; rst_n = 1'b1;
    tick(1);
    chk("R1 readback", rd_data, 1);
    chk("R1 sel_xtal", sel_xtal, 1);
    chk("R1 cpu_hold", cpu_hold, 0);
    chk("R1 xtal_ready", xtal_ready, 1);

    wr(3'b000);
    chk("R2 clear select", rd_data[0], 0);
    tick(1);
    chk("R5 switch to RC", sel_xtal, 0);

    xtal_off = 1'b1; tick(1);
    chk("R10 ready dropped", xtal_ready, 0);
    wr(3'b001);
    chk("R2 refused while off", rd_data[0], 0);
    xtal_off = 1'b0; tick(2);
    wr(3'b001);
    chk("R2 refused while warming", rd_data[0], 0);
    tick(6);
    chk("R9 ready after warm-up", xtal_ready, 1);
    wr(3'b001);
    chk("R2 accepted", rd_data[0], 1);
    tick(1);
    chk("R5 switch to crystal", sel_xtal, 1);

    wr(3'b011);
    chk("R4 status not written", rd_data[1], 0);

    pulse_pd;
    chk("R6 hold on power-down", cpu_hold, 1);
    chk("R6 crystal stopped", xtal_ready, 0);
    pulse_pd; tick(3);
    chk("R11 second pd ignored", cpu_hold, 1);
    chk("R11 crystal still stopped", xtal_ready, 0);
    pulse_wake;
    chk("R8 hold after wake", cpu_hold, 1);
    tick(3);
    chk("R8 hold during warm-up", cpu_hold, 1);
    tick(3);
    chk("R8 released after ready", cpu_hold, 0);
    chk("R8 crystal kept", sel_xtal, 1);
    pulse_wake; tick(1);
    chk("R11 wake while awake ignored", cpu_hold, 0);

    wr(3'b101);
    pulse_pd; tick(2);
    pulse_wake;
    chk("R7 no hold on RC resume", cpu_hold, 0);
    tick(1);
    chk("R7 running on RC", sel_xtal, 0);
    tick(8);
    chk("R7 back on crystal", sel_xtal, 1);

    wr(3'b100); tick(1);
    rst_n = 1'b0; tick(2); rst_n = 1'b1;
    chk("R3 resume bit kept", rd_data[2], 1);
    chk("R3 select bit kept", rd_data[0], 0);
    pulse_pd;
    chk("R6 hold before general reset", cpu_hold, 1);
    rst_n = 1'b0; tick(1); rst_n = 1'b1;
    chk("R3 hold cleared", cpu_hold, 0);
    tick(8);
    chk("R3 crystal restarted", xtal_ready, 1);

    por_n = 1'b0; tick(2); por_n = 1'b1; tick(1);
    chk("R1 readback after second power-on", rd_data, 1);
    tick(4);
    finish_run();
  end
endmodule